// File: doc/BRIEF.md
# 8-bit CPU Register File

This block holds the architectural state of an 8-bit processor core: the accumulator and flag byte, six general byte registers that also act as three 16-bit pairs, a shadow copy of the accumulator/flag pair and of the three general pairs, two 16-bit index registers with byte-addressable halves, the stack pointer, the program counter, an interrupt-vector base byte, a memory-refresh counter and two interrupt-enable flip-flops. It does no decoding and no arithmetic. The surrounding core reads through one byte port and one word port, each selected by a register code, and writes through a single port that takes either a byte or a word.

Separate control inputs exchange the shadow banks in one cycle, advance the refresh counter after an opcode fetch, enable or disable interrupts, and save or restore the enable flag around a non-maskable interrupt. The block also forms the mode-2 interrupt vector address from the vector base and a byte supplied by the interrupting device.

Top module: `regFileTop`

## Requirements
- R1: Byte codes 0..5 select B, C, D, E, H, L. Each can be written and read back on its own without disturbing any other register.
- R2: With wrWord=1 the low three select bits pick a pair: 0=BC, 1=DE, 2=HL, 3=AF, 4=IX, 5=IY, 6=SP, 7=PC. For pairs, the first-named register is bits 15:8 and the second is bits 7:0. The same codes select the word read port.
- R3: Byte code 6 is F and code 7 is A. F keeps all eight written bits, bits 5 and 3 included. Its flag layout is S=7, Z=6, H=4, P/V=2, N=1, C=0.
- R4: exAf swaps AF with its shadow and leaves BC, DE and HL alone. exMain swaps BC, DE and HL with their shadows together and leaves AF alone. A write in the same cycle as an exchange lands in the bank that was active before the swap.
- R5: The refresh register R (byte code 13) adds one to bits 6:0 on each cycle with fetchDone=1. These bits wrap from 127 to 0 and bit 7 holds. A write to R in the same cycle takes priority over the increment.
- R6: intEnable sets both enable flags and intDisable clears both. When both are asserted together, intDisable takes effect.
- R7: nmiAccept copies iff1 into iff2 and clears iff1. nmiReturn loads iff1 from iff2. nmiAccept takes priority over every other enable control, and nmiReturn takes priority over intEnable and intDisable.
- R8: Byte codes 8..11 are IX high, IX low, IY high and IY low, and they match the IX and IY word views. SP and PC are word-only, and each holds its value until it is written.
- R9: vecAddr equals the I register (byte code 12) as bits 15:8 with devVector as bits 7:0.
- R10: Reset clears PC, I, R, iff1 and iff2. Every other register is set to all ones, and that includes the shadow bank.
- R11: The read ports are combinational and, during a write cycle, show the value held before that write. Byte codes 14 and 15 read as zero, and byte writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rdByteSel | input | 4 | Byte read register code |
| rdByte | output | 8 | Byte read data |
| rdWordSel | input | 3 | Word read pair code |
| rdWord | output | 16 | Word read data |
| wrEn | input | 1 | Write strobe |
| wrWord | input | 1 | 1: word write, 0: byte write |
| wrSel | input | 4 | Write register code (byte or pair) |
| wrData | input | 16 | Write data; byte writes use bits 7:0 |
| exAf | input | 1 | Swap AF with its shadow |
| exMain | input | 1 | Swap BC, DE, HL with their shadows |
| fetchDone | input | 1 | Opcode fetch completed; advance R |
| intEnable | input | 1 | Enable interrupts |
| intDisable | input | 1 | Disable interrupts |
| nmiAccept | input | 1 | Non-maskable interrupt accepted |
| nmiReturn | input | 1 | Return from non-maskable interrupt |
| devVector | input | 8 | Vector byte from the interrupting device |
| vecAddr | output | 16 | Mode-2 vector address |
| iff1 | output | 1 | Interrupt enable flag |
| iff2 | output | 1 | Saved interrupt enable flag |

## Verification
A bank-select bit left in the wrong state is visible only through the read ports. The very next read of AF or of a general pair then returns the other bank's contents, so the bench sets the two banks to distinct values before every exchange and reads both sides afterwards. A stuck or misrouted refresh bit shows up within one fetch cycle, and a bit 7 that counts shows up at the first wrap. A wrong enable flag is visible on iff1 and iff2 in the cycle after the control that set it.

// File: rtl/regFilePkg.sv
package regFilePkg;
  localparam int DATA_W        = 8;
  localparam int ADDR_W        = 2 * DATA_W;
  localparam int BYTE_SEL_W    = 4;
  localparam int WORD_SEL_W    = 3;
  localparam int NUM_BYTE_REGS = 14;
  localparam int NUM_GP        = 6;
  localparam int NUM_IDX_BYTES = 4;
  localparam int NUM_PAIRS     = 6;

  localparam int CODE_F   = 6;
  localparam int CODE_A   = 7;
  localparam int CODE_IDX = 8;
  localparam int CODE_I   = 12;
  localparam int CODE_R   = 13;

  localparam logic [WORD_SEL_W-1:0] WSEL_SP = 3'd6;
  localparam logic [WORD_SEL_W-1:0] WSEL_PC = 3'd7;

  typedef struct packed {
    logic [NUM_BYTE_REGS-1:0] byteWe;
    logic                     wordMode;
    logic                     spWe;
    logic                     pcWe;
    logic                     swapAf;
    logic                     swapMain;
    logic                     rInc;
    logic                     iffSet;
    logic                     iffClr;
    logic                     nmiSave;
    logic                     nmiRestore;
  } strobeT;

  function automatic int hiCode(int pair);
    case (pair)
      0: return 0;
      1: return 2;
      2: return 4;
      3: return CODE_A;
      4: return 8;
      default: return 10;
    endcase
  endfunction

  function automatic int loCode(int pair);
    case (pair)
      0: return 1;
      1: return 3;
      2: return 5;
      3: return CODE_F;
      4: return 9;
      default: return 11;
    endcase
  endfunction

  function automatic logic isHighByte(int code);
    return (code == 0) || (code == 2) || (code == 4) ||
           (code == CODE_A) || (code == 8) || (code == 10);
  endfunction
endpackage

// File: rtl/regCtrl.sv
module regCtrl
  import regFilePkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic                  wrWord,
  input  logic [BYTE_SEL_W-1:0] wrSel,
  input  logic                  exAf,
  input  logic                  exMain,
  input  logic                  fetchDone,
  input  logic                  intEnable,
  input  logic                  intDisable,
  input  logic                  nmiAccept,
  input  logic                  nmiReturn,
  output strobeT                strobe
);
  logic [WORD_SEL_W-1:0] pairSel;
  int                    pairIdx;

  assign pairSel = wrSel[WORD_SEL_W-1:0];
  assign pairIdx = int'(pairSel);

  always_comb begin
    strobe          = '0;
    strobe.wordMode = wrWord;
    for (int k = 0; k < NUM_BYTE_REGS; k++) begin
      if (!wrWord) begin
        strobe.byteWe[k] = wrEn && (wrSel == BYTE_SEL_W'(k));
      end else begin
        strobe.byteWe[k] = wrEn && (pairIdx < NUM_PAIRS) &&
                           ((k == hiCode(pairIdx)) || (k == loCode(pairIdx)));
      end
    end
    strobe.spWe       = wrEn && wrWord && (pairSel == WSEL_SP);
    strobe.pcWe       = wrEn && wrWord && (pairSel == WSEL_PC);
    strobe.swapAf     = exAf;
    strobe.swapMain   = exMain;
    strobe.rInc       = fetchDone;
    strobe.nmiSave    = nmiAccept;
    strobe.nmiRestore = nmiReturn && !nmiAccept;
    strobe.iffClr     = intDisable && !nmiAccept && !nmiReturn;
    strobe.iffSet     = intEnable && !intDisable && !nmiAccept && !nmiReturn;
  end

  AST_IFF_ONE_ACTION: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.nmiSave, strobe.nmiRestore, strobe.iffClr, strobe.iffSet})); // R7
  AST_WORD_TWO_BYTES: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrWord && !strobe.spWe && !strobe.pcWe) |-> ($countones(strobe.byteWe) == 2)); // R2
  AST_BYTE_ONE_REG: assert property (@(posedge clk) disable iff (!rstN)
    (!wrWord) |-> $onehot0(strobe.byteWe)); // R1
endmodule

// File: rtl/regData.sv
module regData
  import regFilePkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  strobeT                strobe,
  input  logic [ADDR_W-1:0]     wrData,
  input  logic [BYTE_SEL_W-1:0] rdByteSel,
  input  logic [WORD_SEL_W-1:0] rdWordSel,
  input  logic [DATA_W-1:0]     devVector,
  output logic [DATA_W-1:0]     rdByte,
  output logic [ADDR_W-1:0]     rdWord,
  output logic [ADDR_W-1:0]     vecAddr,
  output logic                  iff1,
  output logic                  iff2
);
  localparam int NUM_VIEW = 1 << BYTE_SEL_W;
  localparam logic [DATA_W-1:0] ONES = '1;

  logic [DATA_W-1:0] mainRegs [2][NUM_GP];
  logic [DATA_W-1:0] afRegs   [2][2];
  logic [DATA_W-1:0] idxRegs  [NUM_IDX_BYTES];
  logic [DATA_W-1:0] iReg, rReg;
  logic [ADDR_W-1:0] spReg, pcReg;
  logic              mainBank, afBank;
  logic              iff1Q, iff2Q;
  logic [DATA_W-1:0] wrLo, wrHi;
  logic [DATA_W-1:0] byteView [NUM_VIEW];

  assign wrLo = wrData[DATA_W-1:0];
  assign wrHi = wrData[ADDR_W-1:DATA_W];

  function automatic logic [DATA_W-1:0] dataFor(int code, logic wordMode,
                                                logic [DATA_W-1:0] hi, logic [DATA_W-1:0] lo);
    return (wordMode && isHighByte(code)) ? hi : lo;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int b = 0; b < 2; b++) begin
        for (int k = 0; k < NUM_GP; k++) mainRegs[b][k] <= ONES;
        afRegs[b][0] <= ONES;
        afRegs[b][1] <= ONES;
      end
      for (int k = 0; k < NUM_IDX_BYTES; k++) idxRegs[k] <= ONES;
      iReg     <= '0;
      rReg     <= '0;
      spReg    <= '1;
      pcReg    <= '0;
      mainBank <= 1'b0;
      afBank   <= 1'b0;
      iff1Q    <= 1'b0;
      iff2Q    <= 1'b0;
    end else begin
      for (int k = 0; k < NUM_GP; k++)
        if (strobe.byteWe[k]) mainRegs[mainBank][k] <= dataFor(k, strobe.wordMode, wrHi, wrLo);
      if (strobe.byteWe[CODE_F]) afRegs[afBank][0] <= dataFor(CODE_F, strobe.wordMode, wrHi, wrLo);
      if (strobe.byteWe[CODE_A]) afRegs[afBank][1] <= dataFor(CODE_A, strobe.wordMode, wrHi, wrLo);
      for (int k = 0; k < NUM_IDX_BYTES; k++)
        if (strobe.byteWe[CODE_IDX+k]) idxRegs[k] <= dataFor(CODE_IDX + k, strobe.wordMode, wrHi, wrLo);
      if (strobe.byteWe[CODE_I]) iReg <= wrLo;
      if (strobe.byteWe[CODE_R]) rReg <= wrLo;
      else if (strobe.rInc) rReg <= {rReg[DATA_W-1], rReg[DATA_W-2:0] + 1'b1};
      if (strobe.spWe) spReg <= wrData;
      if (strobe.pcWe) pcReg <= wrData;
      if (strobe.swapMain) mainBank <= ~mainBank;
      if (strobe.swapAf)   afBank   <= ~afBank;
      if (strobe.nmiSave) begin
        iff2Q <= iff1Q;
        iff1Q <= 1'b0;
      end else if (strobe.nmiRestore) begin
        iff1Q <= iff2Q;
      end else if (strobe.iffClr) begin
        iff1Q <= 1'b0;
        iff2Q <= 1'b0;
      end else if (strobe.iffSet) begin
        iff1Q <= 1'b1;
        iff2Q <= 1'b1;
      end
    end
  end

  always_comb begin
    for (int k = 0; k < NUM_VIEW; k++) byteView[k] = '0;
    for (int k = 0; k < NUM_GP; k++) byteView[k] = mainRegs[mainBank][k];
    byteView[CODE_F] = afRegs[afBank][0];
    byteView[CODE_A] = afRegs[afBank][1];
    for (int k = 0; k < NUM_IDX_BYTES; k++) byteView[CODE_IDX+k] = idxRegs[k];
    byteView[CODE_I] = iReg;
    byteView[CODE_R] = rReg;
  end

  assign rdByte = byteView[rdByteSel];

  always_comb begin
    case (rdWordSel)
      WSEL_SP: rdWord = spReg;
      WSEL_PC: rdWord = pcReg;
      default: rdWord = {byteView[hiCode(int'(rdWordSel))], byteView[loCode(int'(rdWordSel))]};
    endcase
  end

  assign vecAddr = {iReg, devVector};
  assign iff1    = iff1Q;
  assign iff2    = iff2Q;

  AST_R_COUNTS: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rInc && !strobe.byteWe[CODE_R]) |=>
      (rReg[DATA_W-2:0] == $past(rReg[DATA_W-2:0]) + 1'b1) &&
      (rReg[DATA_W-1] == $past(rReg[DATA_W-1]))); // R5
  AST_R_WRITE_WINS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.byteWe[CODE_R] |=> (rReg == $past(wrLo))); // R5
  AST_IFF_SET_BOTH: assert property (@(posedge clk) disable iff (!rstN)
    strobe.iffSet |=> (iff1Q && iff2Q)); // R6
  AST_NMI_SAVE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.nmiSave |=> (!iff1Q && (iff2Q == $past(iff1Q)))); // R7
  AST_AF_SWAP: assert property (@(posedge clk) disable iff (!rstN)
    strobe.swapAf |=> (afBank != $past(afBank))); // R4
  AST_MAIN_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.swapMain |=> $stable(mainBank)); // R4
  AST_PC_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.pcWe |=> $stable(pcReg)); // R8
endmodule

// File: rtl/regFileTop.sv
module regFileTop
  import regFilePkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [BYTE_SEL_W-1:0] rdByteSel,
  output logic [DATA_W-1:0]     rdByte,
  input  logic [WORD_SEL_W-1:0] rdWordSel,
  output logic [ADDR_W-1:0]     rdWord,
  input  logic                  wrEn,
  input  logic                  wrWord,
  input  logic [BYTE_SEL_W-1:0] wrSel,
  input  logic [ADDR_W-1:0]     wrData,
  input  logic                  exAf,
  input  logic                  exMain,
  input  logic                  fetchDone,
  input  logic                  intEnable,
  input  logic                  intDisable,
  input  logic                  nmiAccept,
  input  logic                  nmiReturn,
  input  logic [DATA_W-1:0]     devVector,
  output logic [ADDR_W-1:0]     vecAddr,
  output logic                  iff1,
  output logic                  iff2
);
  strobeT strobe;

  regCtrl i_regCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .wrEn       (wrEn),
    .wrWord     (wrWord),
    .wrSel      (wrSel),
    .exAf       (exAf),
    .exMain     (exMain),
    .fetchDone  (fetchDone),
    .intEnable  (intEnable),
    .intDisable (intDisable),
    .nmiAccept  (nmiAccept),
    .nmiReturn  (nmiReturn),
    .strobe     (strobe)
  );

  regData i_regData (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .wrData    (wrData),
    .rdByteSel (rdByteSel),
    .rdWordSel (rdWordSel),
    .devVector (devVector),
    .rdByte    (rdByte),
    .rdWord    (rdWord),
    .vecAddr   (vecAddr),
    .iff1      (iff1),
    .iff2      (iff2)
  );
endmodule

// File: tb/test_regFileTop.sv
`timescale 1ns/1ps
module test_regFileTop;
  logic        clk = 1'b0;
  logic        rstN;
  logic [3:0]  rdByteSel;
  logic [7:0]  rdByte;
  logic [2:0]  rdWordSel;
  logic [15:0] rdWord;
  logic        wrEn, wrWord;
  logic [3:0]  wrSel;
  logic [15:0] wrData;
  logic        exAf, exMain, fetchDone, intEnable, intDisable, nmiAccept, nmiReturn;
  logic [7:0]  devVector;
  logic [15:0] vecAddr;
  logic        iff1, iff2;

  int checks = 0;
  int errors = 0;
  logic [7:0]  bm [16];
  logic [7:0]  shMain [6];
  logic [7:0]  shAf [2];
  logic [15:0] spM, pcM;

  always #2.5 clk = ~clk;

  regFileTop i_regFileTop (
    .clk(clk), .rstN(rstN), .rdByteSel(rdByteSel), .rdByte(rdByte),
    .rdWordSel(rdWordSel), .rdWord(rdWord), .wrEn(wrEn), .wrWord(wrWord),
    .wrSel(wrSel), .wrData(wrData), .exAf(exAf), .exMain(exMain),
    .fetchDone(fetchDone), .intEnable(intEnable), .intDisable(intDisable),
    .nmiAccept(nmiAccept), .nmiReturn(nmiReturn), .devVector(devVector),
    .vecAddr(vecAddr), .iff1(iff1), .iff2(iff2)
  );

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int hiOf(int w);
    case (w) 0: return 0; 1: return 2; 2: return 4; 3: return 7; 4: return 8; default: return 10; endcase
  endfunction
  function automatic int loOf(int w);
    case (w) 0: return 1; 1: return 3; 2: return 5; 3: return 6; 4: return 9; default: return 11; endcase
  endfunction
  function automatic logic [15:0] expWord(int w);
    if (w == 6) return spM;
    if (w == 7) return pcM;
    return {bm[hiOf(w)], bm[loOf(w)]};
  endfunction

  task automatic idle();
    wrEn = 0; wrWord = 0; wrSel = 0; wrData = 0; exAf = 0; exMain = 0; fetchDone = 0;
    intEnable = 0; intDisable = 0; nmiAccept = 0; nmiReturn = 0;
  endtask

  task automatic checkAll(string req);
    for (int c = 0; c < 16; c++) begin
      rdByteSel = 4'(c);
      #0.1;
      chk(req, {8'h00, rdByte}, {8'h00, bm[c]});
    end
    for (int w = 0; w < 8; w++) begin
      rdWordSel = 3'(w);
      #0.1;
      chk(req, rdWord, expWord(w));
    end
  endtask

  task automatic writeByte(int code, logic [7:0] val);
    @(negedge clk);
    wrEn = 1; wrWord = 0; wrSel = 4'(code); wrData = {8'hC3, val};
    @(negedge clk);
    idle();
    if (code < 14) bm[code] = val;
  endtask

  task automatic writeWord(int w, logic [15:0] val);
    @(negedge clk);
    wrEn = 1; wrWord = 1; wrSel = 4'(w); wrData = val;
    @(negedge clk);
    idle();
    if (w == 6) spM = val;
    else if (w == 7) pcM = val;
    else begin bm[hiOf(w)] = val[15:8]; bm[loOf(w)] = val[7:0]; end
  endtask

  task automatic swapMainModel();
    for (int k = 0; k < 6; k++) begin
      logic [7:0] t;
      t = bm[k]; bm[k] = shMain[k]; shMain[k] = t;
    end
  endtask

  task automatic swapAfModel();
    logic [7:0] t0, t1;
    t0 = bm[6]; t1 = bm[7];
    bm[6] = shAf[0]; bm[7] = shAf[1];
    shAf[0] = t0; shAf[1] = t1;
  endtask

  task automatic pulseCtrl(logic en, logic dis, logic acc, logic ret);
    @(negedge clk);
    intEnable = en; intDisable = dis; nmiAccept = acc; nmiReturn = ret;
    @(negedge clk);
    idle();
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    #(5.0 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    idle();
    rstN = 0; rdByteSel = 0; rdWordSel = 0; devVector = 0;
    for (int c = 0; c < 16; c++) bm[c] = (c < 12) ? 8'hFF : 8'h00;
    for (int k = 0; k < 6; k++) shMain[k] = 8'hFF;
    shAf[0] = 8'hFF; shAf[1] = 8'hFF;
    spM = 16'hFFFF; pcM = 16'h0000;
    repeat (3) @(negedge clk);
    rstN = 1;

    // R10: reset values
    checkAll("R10");
    chk("R10 iff", {iff1, iff2}, 2'b00);

    // R1 R3 R8: every byte code written with a distinct value
    for (int c = 0; c < 14; c++) begin
      writeByte(c, 8'(c * 17 + 3));
      checkAll("R1/R3/R8 byte sweep");
    end
    // R3: F keeps bits 5 and 3
    writeByte(6, 8'h28);
    checkAll("R3 F spare bits");
    writeByte(6, 8'hD7);
    checkAll("R3 F flag bits");

    // R11: unused codes ignore writes and read zero
    writeByte(14, 8'h5A);
    checkAll("R11 code 14");
    writeByte(15, 8'hA5);
    checkAll("R11 code 15");

    // R2 R8: word writes on every pair code
    for (int w = 0; w < 8; w++) begin
      writeWord(w, 16'hA000 ^ 16'(w * 16'h1357));
      checkAll("R2/R8 word sweep");
    end

    // R11: read shows old value during the write cycle
    @(negedge clk);
    rdByteSel = 4'd0;
    wrEn = 1; wrWord = 0; wrSel = 4'd0; wrData = 16'h00E1;
    #1;
    chk("R11 old during write", {8'h00, rdByte}, {8'h00, bm[0]});
    @(negedge clk);
    idle();
    bm[0] = 8'hE1;
    chk("R11 new after write", {8'h00, rdByte}, 16'h00E1);

    // R4: exchanges
    writeWord(0, 16'h1111); writeWord(1, 16'h2222); writeWord(2, 16'h3333); writeWord(3, 16'h4444);
    @(negedge clk); exMain = 1; @(negedge clk); idle(); swapMainModel();
    checkAll("R4 exMain first");
    writeWord(0, 16'h5555);
    @(negedge clk); exMain = 1; @(negedge clk); idle(); swapMainModel();
    checkAll("R4 exMain back");
    @(negedge clk); exAf = 1; @(negedge clk); idle(); swapAfModel();
    checkAll("R4 exAf first");
    @(negedge clk); exAf = 1; @(negedge clk); idle(); swapAfModel();
    checkAll("R4 exAf back");
    // R4: write in the exchange cycle goes to the pre-swap bank
    @(negedge clk);
    exAf = 1; wrEn = 1; wrWord = 1; wrSel = 4'd3; wrData = 16'h6A6B;
    @(negedge clk); idle();
    bm[7] = 8'h6A; bm[6] = 8'h6B; swapAfModel();
    checkAll("R4 write with exAf");
    @(negedge clk); exAf = 1; exMain = 1; @(negedge clk); idle(); swapAfModel(); swapMainModel();
    checkAll("R4 both exchanges");

    // R5: refresh counting with bit 7 held
    writeByte(13, 8'h80);
    rdByteSel = 4'd13;
    @(negedge clk);
    fetchDone = 1;
    for (int n = 1; n <= 130; n++) begin
      @(negedge clk);
      chk("R5 count bit7=1", {8'h00, rdByte}, {8'h00, 1'b1, 7'(n)});
    end
    idle();
    bm[13] = {1'b1, 7'(130)};
    writeByte(13, 8'h7E);
    rdByteSel = 4'd13;
    @(negedge clk); fetchDone = 1;
    @(negedge clk); chk("R5 7E+1", {8'h00, rdByte}, 16'h007F);
    @(negedge clk); chk("R5 wrap bit7=0", {8'h00, rdByte}, 16'h0000);
    // R5: write wins over increment
    wrEn = 1; wrWord = 0; wrSel = 4'd13; wrData = 16'h0042;
    @(negedge clk); idle();
    chk("R5 write wins", {8'h00, rdByte}, 16'h0042);
    bm[13] = 8'h42;
    checkAll("R5 others untouched");

    // R6 R7: interrupt enable flags
    pulseCtrl(1, 0, 0, 0); chk("R6 enable", {iff1, iff2}, 2'b11);
    pulseCtrl(0, 1, 0, 0); chk("R6 disable", {iff1, iff2}, 2'b00);
    pulseCtrl(1, 0, 0, 0);
    pulseCtrl(1, 1, 0, 0); chk("R6 disable wins", {iff1, iff2}, 2'b00);
    pulseCtrl(1, 0, 0, 0);
    pulseCtrl(0, 0, 1, 0); chk("R7 accept saves", {iff1, iff2}, 2'b01);
    pulseCtrl(0, 0, 0, 1); chk("R7 return restores", {iff1, iff2}, 2'b11);
    pulseCtrl(0, 1, 0, 0);
    pulseCtrl(0, 0, 1, 0); chk("R7 accept when off", {iff1, iff2}, 2'b00);
    pulseCtrl(0, 0, 0, 1); chk("R7 return when off", {iff1, iff2}, 2'b00);
    pulseCtrl(1, 0, 0, 0);
    pulseCtrl(1, 1, 1, 1); chk("R7 accept priority", {iff1, iff2}, 2'b01);
    pulseCtrl(1, 1, 0, 1); chk("R7 return priority", {iff1, iff2}, 2'b11);

    // R9: vector address
    for (int v = 0; v < 256; v += 17) begin
      writeByte(12, 8'(v));
      devVector = ~8'(v);
      #0.1;
      chk("R9 vector", vecAddr, {8'(v), ~8'(v)});
    end
    checkAll("R9 final state");

    summary();
    $finish;
  end
endmodule